// File: doc/BRIEF.md
# Buffered SPI Host Controller

This block is a memory-mapped SPI host engine. Software fills a byte-wide command buffer with the bytes to send, programs a control register with the byte count, clock speed code, bus mode and target chip select, and sets a start bit. The engine then clocks the bytes out on MOSI, most significant bit first. At the same time it captures the byte returned on MISO into a separate response buffer at the same index. When the last byte is done it sets a completion event. The event can raise an interrupt, and software clears it by writing a one to it.

Register and buffer access uses a simple single-cycle bus. Writes take effect on the clock edge. Reads return data on the cycle after the read request. Longer messages are sent as a series of transfers of at most `MAX_BYTES` bytes each. A force bit keeps the chosen chip select low across several transfers. The SCK period is set by a 3-bit speed code and is derived from the system clock.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the control, event and mask registers read 0, all chip selects are high (inactive), SCK is low and `irq` is low.
- R2: Setting bit 0 of the control word (offset 0x400) with byte count N in bits 16:8 sends command bytes 0 to N-1 on MOSI in index order, most significant bit first, with exactly 8*N SCK rising edges. The command buffer is written with one byte per access at offset 0x000 plus the index, using bus data bits 7:0.
- R3: The byte received during the transfer of command byte i is stored at response index i. Response index i is read back at offset 0x200 plus i, in bus data bits 7:0.
- R4: Control bit 2 selects the bus mode. With bit 2 = 0 (mode 0), SCK idles low. With bit 2 = 1 (mode 3), SCK idles high. In both modes MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R5: With speed code S in control bits 7:5, each high phase and each low phase of SCK within a byte lasts (S+1)*`HALF_UNIT` system clocks.
- R6: Chip select code C in control bits 27:25 drives `cs_n[C]` low while a transfer runs or while force bit 4 is 1. At most one chip select is low at any time. A code at or above `NUM_CS` drives none low. Clearing the force bit while idle releases the line.
- R7: Control bit 0 reads 1 from the start request until the transfer ends, and then reads 0. While a transfer runs, writes to the control register and to the command buffer are ignored.
- R8: At the end of each transfer, bit 8 of the event register (offset 0x420) becomes 1. Writing 1 to bit 8 clears it. Writing 0 to bit 8 leaves it unchanged. If a completion and a clearing write happen in the same cycle, the completion wins.
- R9: `irq` equals event bit 8 AND NOT mask bit 8 (offset 0x424). A mask bit of 1 blocks the interrupt.
- R10: A start request with a byte count of 0 produces no SCK edge and sets the completion event.
- R11: A byte count above `MAX_BYTES` is treated as `MAX_BYTES`. The control register still reads back the value that was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of a register or buffer entry |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; data is returned on the next cycle |
| bus_rdata | output | 32 | Read data |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data from the host |
| miso | input | 1 | Serial data to the host |
| cs_n | output | NUM_CS | Chip selects, active low |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters: `MAX_BYTES` = 320, `HALF_UNIT` = 1 and `NUM_CS` = 7. With these values a full 320-byte transfer and an over-limit count of 400 finish in a few thousand cycles, so the buffer boundary and the clamping are both tested. Because `HALF_UNIT` = 1, every speed code gives SCK phases of one to eight clocks. This lets the bench measure the high-phase length for random codes, in both modes, and against all seven chip selects.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam logic [11:0] OFS_RSP  = 12'h200;
    localparam logic [11:0] OFS_CTL  = 12'h400;
    localparam logic [11:0] OFS_EVT  = 12'h420;
    localparam logic [11:0] OFS_MASK = 12'h424;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_LOAD,
        ENG_LOW,
        ENG_HIGH
    } eng_state_e;

    typedef struct packed {
        logic [2:0] csel;
        logic [8:0] count;
        logic [2:0] speed;
        logic       force_cs;
        logic       mode3;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.csel     = w[27:25];
        c.count    = w[16:8];
        c.speed    = w[7:5];
        c.force_cs = w[4];
        c.mode3    = w[2];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c, input logic go);
        return {4'b0, c.csel, 8'b0, c.count, c.speed, c.force_cs, 1'b0, c.mode3, 1'b0, go};
    endfunction

endpackage

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
    parameter int DEPTH = 320,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_host_pkg::*;
#(
    parameter int MAX_BYTES = 320,
    parameter int DIV_W     = 4,
    localparam int IW = $clog2(MAX_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [8:0]       byte_count,
    input  logic [DIV_W-1:0] half_len,
    input  logic             cpol,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [IW-1:0]    tx_raddr,
    input  logic [7:0]       tx_rdata,
    output logic             rx_we,
    output logic [IW-1:0]    rx_waddr,
    output logic [7:0]       rx_wdata
);
    typedef struct packed {
        eng_state_e       st;
        logic [8:0]       idx;
        logic [8:0]       nbytes;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] tick;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             sck;
        logic             mosi;
        logic             done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rx_we  = 1'b0;
        unique case (q.st)
            ENG_IDLE: begin
                d.sck = cpol;
                if (start) begin
                    if (byte_count == 9'd0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st     = ENG_FETCH;
                        d.idx    = 9'd0;
                        d.nbytes = byte_count;
                    end
                end
            end
            ENG_FETCH: d.st = ENG_LOAD;
            ENG_LOAD: begin
                d.tx   = tx_rdata;
                d.mosi = tx_rdata[7];
                d.sck  = 1'b0;
                d.bitn = 3'd0;
                d.tick = '0;
                d.st   = ENG_LOW;
            end
            ENG_LOW: begin
                if (q.tick == half_len - DIV_W'(1)) begin
                    d.tick = '0;
                    d.sck  = 1'b1;
                    d.rx   = {q.rx[6:0], miso};
                    d.st   = ENG_HIGH;
                end else begin
                    d.tick = q.tick + DIV_W'(1);
                end
            end
            ENG_HIGH: begin
                if (q.tick == half_len - DIV_W'(1)) begin
                    d.tick = '0;
                    if (q.bitn == 3'd7) begin
                        rx_we = 1'b1;
                        d.sck = cpol;
                        if (q.idx + 9'd1 == q.nbytes) begin
                            d.st   = ENG_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.idx = q.idx + 9'd1;
                            d.st  = ENG_FETCH;
                        end
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.tx   = {q.tx[6:0], 1'b0};
                        d.mosi = q.tx[6];
                        d.sck  = 1'b0;
                        d.st   = ENG_LOW;
                    end
                end else begin
                    d.tick = q.tick + DIV_W'(1);
                end
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ENG_IDLE, default: '0};
        else        q <= d;
    end

    assign sck      = q.sck;
    assign mosi     = q.mosi;
    assign busy     = (q.st != ENG_IDLE);
    assign done     = q.done;
    assign tx_raddr = q.idx[IW-1:0];
    assign rx_waddr = q.idx[IW-1:0];
    assign rx_wdata = q.rx;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int MAX_BYTES = 320,
    parameter int HALF_UNIT = 1,
    parameter int NUM_CS    = 7,
    localparam int IW    = $clog2(MAX_BYTES),
    localparam int DIV_W = $clog2(8 * HALF_UNIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    typedef struct packed {
        ctrl_t       ctrl;
        logic        start;
        logic        ev;
        logic        mask;
        logic        rsel;
        logic [31:0] rdata;
    } regs_t;

    regs_t q, d;

    logic             eng_busy, eng_done, busy_all;
    logic             is_cmd, is_rsp;
    logic [8:0]       eff_count;
    logic [DIV_W-1:0] half_len;
    logic [IW-1:0]    tx_raddr, rx_waddr;
    logic [7:0]       tx_rdata, rx_wdata, rsp_rdata;
    logic             rx_we;
    logic             unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[24:17], bus_wdata[3], bus_wdata[1]};

    assign busy_all  = q.start | eng_busy;
    assign is_cmd    = (bus_addr[11:9] == 3'b000) && (bus_addr[8:0] < 9'(MAX_BYTES));
    assign is_rsp    = (bus_addr[11:9] == 3'b001) && (bus_addr[8:0] < 9'(MAX_BYTES));
    assign eff_count = (q.ctrl.count > 9'(MAX_BYTES)) ? 9'(MAX_BYTES) : q.ctrl.count;
    assign half_len  = DIV_W'((32'(q.ctrl.speed) + 32'd1) * HALF_UNIT);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (bus_we && bus_addr == OFS_CTL && !busy_all) begin
            d.ctrl  = ctrl_unpack(bus_wdata);
            d.start = bus_wdata[0];
        end
        if (bus_we && bus_addr == OFS_MASK) d.mask = bus_wdata[8];
        if (bus_we && bus_addr == OFS_EVT && bus_wdata[8]) d.ev = 1'b0;
        if (eng_done) d.ev = 1'b1;
        if (bus_re) begin
            d.rsel = is_rsp;
            unique case (bus_addr)
                OFS_CTL:  d.rdata = ctrl_pack(q.ctrl, busy_all);
                OFS_EVT:  d.rdata = {23'b0, q.ev, 8'b0};
                OFS_MASK: d.rdata = {23'b0, q.mask, 8'b0};
                default:  d.rdata = 32'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rsel ? {24'b0, rsp_rdata} : q.rdata;
    assign irq       = q.ev & ~q.mask;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !((busy_all || q.ctrl.force_cs) && (q.ctrl.csel == 3'(i)));
    end

    spi_byte_ram #(.DEPTH(MAX_BYTES)) u_cmd_ram (
        .clk   (clk),
        .we    (bus_we && is_cmd && !busy_all),
        .waddr (bus_addr[IW-1:0]),
        .wdata (bus_wdata[7:0]),
        .raddr (tx_raddr),
        .rdata (tx_rdata)
    );

    spi_byte_ram #(.DEPTH(MAX_BYTES)) u_rsp_ram (
        .clk   (clk),
        .we    (rx_we),
        .waddr (rx_waddr),
        .wdata (rx_wdata),
        .raddr (bus_addr[IW-1:0]),
        .rdata (rsp_rdata)
    );

    spi_shift_engine #(.MAX_BYTES(MAX_BYTES), .DIV_W(DIV_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (q.start),
        .byte_count (eff_count),
        .half_len   (half_len),
        .cpol       (q.ctrl.mode3),
        .miso       (miso),
        .sck        (sck),
        .mosi       (mosi),
        .busy       (eng_busy),
        .done       (eng_done),
        .tx_raddr   (tx_raddr),
        .tx_rdata   (tx_rdata),
        .rx_we      (rx_we),
        .rx_waddr   (rx_waddr),
        .rx_wdata   (rx_wdata)
    );
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk #(
    parameter int NUM_CS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              eng_done,
    input logic              ev,
    input logic              mask,
    input logic              irq,
    input logic              sck,
    input logic              mosi,
    input logic              mode3,
    input logic [8:0]        count,
    input logic [NUM_CS-1:0] cs_n
);
    // R6
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R7
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(count) && $stable(mode3)));

    // R8
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> ev);

    // R9
    irq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (irq || mask));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq);

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(mode3)) |-> (sck == mode3));

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_all),
    .eng_done (eng_done),
    .ev       (q.ev),
    .mask     (q.mask),
    .irq      (irq),
    .sck      (sck),
    .mosi     (mosi),
    .mode3    (q.ctrl.mode3),
    .count    (q.ctrl.count),
    .cs_n     (cs_n)
);

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
    localparam int MAXB = 320;
    localparam int NCS  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso, irq;
    logic [NCS-1:0] cs_n;

    always #2 clk = ~clk;

    spi_host_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    int unsigned tests = 0, fails = 0;
    logic [7:0]  cmd_mem [0:511];
    logic [7:0]  sl_got  [0:511];
    int unsigned sl_bits = 0;
    logic [7:0]  sl_shift = '0;
    logic [7:0]  salt = 8'h00;
    int unsigned hi_run = 0, last_hi = 0, mosi_viol = 0;
    logic        prev_sck = 1'b0, prev_mosi = 1'b0;

    function automatic logic [7:0] resp_fn(input int unsigned i, input logic [7:0] s);
        return 8'((i * 37) + s) ^ 8'h5A;
    endfunction

    function automatic logic miso_of(input int unsigned bits, input logic [7:0] s);
        logic [7:0] b;
        b = resp_fn(bits / 8, s);
        return b[7 - (bits % 8)];
    endfunction

    function automatic logic [31:0] mk_ctrl(input int sel, input int n, input int spd,
                                            input bit frc, input bit m3, input bit go);
        return (32'(sel) << 25) | (32'(n) << 8) | (32'(spd) << 5) |
               (32'(frc) << 4) | (32'(m3) << 2) | 32'(go);
    endfunction

    assign miso = miso_of(sl_bits, salt);

    // slave device model: samples MOSI on the rising SCK edge
    always @(posedge sck) begin
        if (~&cs_n) begin
            sl_shift = {sl_shift[6:0], mosi};
            if (sl_bits % 8 == 7) sl_got[sl_bits / 8] = sl_shift;
            sl_bits++;
        end
    end

    // line monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (sck && prev_sck && mosi != prev_mosi) mosi_viol++;
        if (sck && ~&cs_n) hi_run++;
        else begin
            if (prev_sck && !sck && hi_run > 0) last_hi = hi_run;
            hi_run = 0;
        end
        prev_sck  = sck;
        prev_mosi = mosi;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int k = 0; k < 30000; k++) begin
            bus_rd(12'h420, v);
            if (v[8]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic load_cmd(input int n);
        for (int i = 0; i < n && i < MAXB; i++) begin
            cmd_mem[i] = 8'($urandom);
            bus_wr(12'(i), {24'b0, cmd_mem[i]});
        end
    endtask

    task automatic run_xfer(input int n, input bit m3, input int spd, input int sel);
        bit ok;
        int eff, bad_tx, bad_rx;
        logic [31:0] v;
        eff = (n > MAXB) ? MAXB : n;
        load_cmd(eff);
        bus_wr(12'h400, mk_ctrl(sel, 0, spd, 0, m3, 0));
        repeat (3) @(negedge clk);
        salt = 8'($urandom);
        sl_bits = 0; mosi_viol = 0; last_hi = 0;
        bus_wr(12'h400, mk_ctrl(sel, n, spd, 0, m3, 1));
        wait_done(ok);
        check(ok, "R8 completion event", ok, 1);
        check(sl_bits == 32'(eff) * 8, "R2 edge count", sl_bits, eff * 8);
        bad_tx = 0; bad_rx = 0;
        for (int i = 0; i < eff; i++) begin
            if (sl_got[i] !== cmd_mem[i]) bad_tx++;
            bus_rd(12'h200 + 12'(i), v);
            if (v[7:0] !== resp_fn(i, salt)) bad_rx++;
        end
        check(bad_tx == 0, "R2 MOSI bytes", bad_tx, 0);
        check(bad_rx == 0, "R3 response bytes", bad_rx, 0);
        check(sck == m3, "R4 idle level", sck, m3);
        check(mosi_viol == 0, "R4 MOSI changed while SCK high", mosi_viol, 0);
        if (eff > 0) check(last_hi == 32'(spd + 1), "R5 SCK high phase", last_hi, spd + 1);
        bus_rd(12'h400, v);
        check(v[0] == 1'b0, "R7 GO self-clear", v[0], 0);
        bus_wr(12'h420, 32'h100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit ok;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(12'h400, v); check(v == 0, "R1 control reset", v, 0);
        bus_rd(12'h420, v); check(v == 0, "R1 event reset", v, 0);
        bus_rd(12'h424, v); check(v == 0, "R1 mask reset", v, 0);
        check(cs_n == '1, "R1 chip selects idle", cs_n, 7'h7f);
        check(irq == 0 && sck == 0, "R1 irq and sck low", {irq, sck}, 0);

        // R2 R3 R4 R5: directed transfers, both modes
        run_xfer(5, 0, 0, 0);
        run_xfer(6, 1, 3, 4);
        run_xfer(MAXB, 1, 0, 6);

        // R8 R9: event, write of zero, mask
        load_cmd(2);
        bus_wr(12'h400, mk_ctrl(2, 2, 1, 0, 0, 1));
        wait_done(ok);
        @(negedge clk);
        check(irq == 1, "R9 irq on unmasked event", irq, 1);
        bus_wr(12'h420, 32'h0);
        bus_rd(12'h420, v); check(v[8] == 1, "R8 zero write keeps event", v[8], 1);
        bus_wr(12'h424, 32'h100);
        @(negedge clk);
        check(irq == 0, "R9 mask blocks irq", irq, 0);
        bus_wr(12'h420, 32'h100);
        bus_rd(12'h420, v); check(v[8] == 0, "R8 W1C clears", v[8], 0);
        bus_wr(12'h424, 32'h0);
        @(negedge clk);
        check(irq == 0, "R9 irq low after clear", irq, 0);

        // R6 R7: busy readback, select during transfer, ignored writes
        load_cmd(4);
        sl_bits = 0;
        bus_wr(12'h400, mk_ctrl(5, 4, 7, 0, 0, 1));
        bus_rd(12'h400, v); check(v[0] == 1, "R7 GO reads busy", v[0], 1);
        repeat (20) @(negedge clk);
        check(cs_n == ~(7'b1 << 5), "R6 select during transfer", cs_n, ~(7'b1 << 5));
        bus_wr(12'h400, mk_ctrl(1, 9, 0, 0, 1, 1));
        bus_wr(12'h000, 32'h0);
        wait_done(ok);
        bus_rd(12'h400, v);
        check(v[16:8] == 9'd4 && v[2] == 0, "R7 control write ignored", v, mk_ctrl(5, 4, 7, 0, 0, 0));
        check(sl_bits == 32, "R7 no second transfer", sl_bits, 32);
        check(sl_got[0] == cmd_mem[0], "R7 command write ignored", sl_got[0], cmd_mem[0]);
        check(cs_n == '1, "R6 release after transfer", cs_n, 7'h7f);
        bus_wr(12'h420, 32'h100);

        // R6 force, out-of-range code
        bus_wr(12'h400, mk_ctrl(2, 0, 0, 1, 0, 0));
        check(cs_n == ~(7'b1 << 2), "R6 force select", cs_n, ~(7'b1 << 2));
        bus_wr(12'h400, mk_ctrl(7, 0, 0, 1, 0, 0));
        check(cs_n == '1, "R6 code 7 selects none", cs_n, 7'h7f);
        bus_wr(12'h400, mk_ctrl(1, 0, 0, 1, 0, 0));
        load_cmd(3);
        bus_wr(12'h400, mk_ctrl(1, 3, 0, 1, 0, 1));
        wait_done(ok);
        check(cs_n == ~(7'b1 << 1), "R6 force held after transfer", cs_n, ~(7'b1 << 1));
        bus_wr(12'h400, mk_ctrl(1, 0, 0, 0, 0, 0));
        check(cs_n == '1, "R6 force clear releases", cs_n, 7'h7f);
        bus_wr(12'h420, 32'h100);

        // R10 zero count
        sl_bits = 0;
        bus_wr(12'h400, mk_ctrl(3, 0, 2, 0, 0, 1));
        repeat (4) @(negedge clk);
        bus_rd(12'h420, v);
        check(v[8] == 1, "R10 zero count completes", v[8], 1);
        check(sl_bits == 0, "R10 no SCK edges", sl_bits, 0);
        bus_wr(12'h420, 32'h100);

        // R11 over-limit count
        run_xfer(400, 0, 0, 0);
        bus_rd(12'h400, v);
        check(v[16:8] == 9'd400, "R11 count readback", v[16:8], 400);

        // constrained random transfers (R2 R3 R4 R5)
        for (int t = 0; t < 10; t++) begin
            run_xfer(1 + int'($urandom % 24), bit'($urandom % 2), int'($urandom % 8),
                     int'($urandom % NCS));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule